// File: doc/BRIEF.md
# Word-Fetch Byte Instruction Predecoder

This block is the instruction front end for a stack processor whose instructions are single bytes and whose memory can only be read one 32-bit word at a time. It reads words from memory, keeps the word being decoded plus one word of lookahead, and takes one instruction byte per cycle from the head word. Each byte carries a 4-bit function code in its upper half and a 4-bit data nibble in its lower half.

Prefix and negative-prefix bytes are never handed on. Their nibbles are folded into an operand register, so the execution side only sees complete instructions: a function code together with a full-width operand. A redirect (a jump taken by the core) drops every buffered byte and any partly built operand, then restarts fetching at the target. The target may be any byte address. Decoding starts inside the first fetched word at the byte the address selects.

The memory port is a request/response pair. `mem_req` asks for the word at `mem_addr` in the cycle it is high. The memory answers with `mem_rvalid` and `mem_rdata` in some later cycle, never in the same cycle. Responses come back in request order.

Top module: `bytecode_fetch_top`

## Requirements
- R1: While reset is active and in the first cycle after it, `iss_valid` is low, `mem_req` is high and `mem_addr` equals `RESET_ADDR`. Decoding begins at byte 0 of that word.
- R2: A word holds four bytes in little-endian order: the byte at word address + k sits in bits 8k+7..8k. Bytes are decoded in ascending address order, at most one per cycle, whenever a buffered word is available. An instruction appears on the issue port in the cycle after its last byte is decoded. `iss_fn` is bits 7..4 of that byte.
- R3: A byte whose function code is neither 0x2 nor 0x6 (including 0xF, operate) issues with operand = (operand register OR its low nibble). The operand register then becomes zero.
- R4: A byte with function code 0x2 (prefix) issues nothing. It sets the operand register to (operand register OR nibble) shifted left by 4.
- R5: A byte with function code 0x6 (negative prefix) issues nothing. It sets the operand register to the bitwise complement of (operand register OR nibble), shifted left by 4.
- R6: At most one read is outstanding, so `mem_req` is never high in two consecutive cycles. Request addresses are word aligned and step by 4 between redirects. No request is made while two words are held in the buffer.
- R7: A redirect empties the buffer and clears the operand register. `iss_valid` is low in the following cycle. The next request is for the word containing the target, and decoding starts at byte (target mod 4) of that word.
- R8: Read data returned in the same cycle as a redirect, or answering a request made in or before a redirect cycle, is dropped and never decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Word read request, one cycle per read |
| mem_addr | output | ADDR_W | Word-aligned byte address of the read |
| mem_rdata | input | WORD_W | Returned word |
| mem_rvalid | input | 1 | `mem_rdata` is valid this cycle |
| redir_valid | input | 1 | Redirect fetch to `redir_addr` |
| redir_addr | input | ADDR_W | Byte address of the redirect target |
| iss_valid | output | 1 | A complete instruction is presented |
| iss_fn | output | 4 | Function code of the issued instruction |
| iss_opnd | output | OPND_W | Accumulated operand of the issued instruction |

## Verification
A redirect can land in the same cycle as returning read data, in the same cycle as a new request, or while a read is still in flight. In each case the data tied to the old path must vanish. The bench provokes this by firing redirects at random moments and, in one phase, deliberately on the cycle a response is driven. It also issues bursts of back-to-back redirects. A reference walk over the byte stream, restarted at each target with a zero operand, judges the result: every issued function code and operand must match the walk. The first issue after a dropped response is tagged as the stale-data check, and the issue port must stay quiet in the cycle after every redirect.

// File: rtl/wfp_pkg.sv
package wfp_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    typedef logic [NIB_W-1:0] fn_t;
    localparam fn_t FN_PFIX = 4'h2;
    localparam fn_t FN_NFIX = 4'h6;
endpackage

// File: rtl/wfp_fetch_ctl.sv
module wfp_fetch_ctl #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int BUF_WORDS  = 2,
    parameter int CNT_W      = 2,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  buf_cnt,
    input  logic              mem_rvalid,
    input  logic              redir_valid,
    input  logic [ADDR_W-1:0] redir_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              push
);
    localparam int OFF_W = $clog2(WORD_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] fa;
        logic              pend;
        logic              stale;
    } fst_t;

    fst_t st_d, st_q;
    logic resp_live;

    always_comb begin
        st_d      = st_q;
        mem_req   = !st_q.pend && (buf_cnt < CNT_W'(BUF_WORDS));
        resp_live = mem_rvalid && st_q.pend;
        push      = resp_live && !st_q.stale && !redir_valid;
        if (mem_req) begin
            st_d.pend  = 1'b1;
            st_d.stale = 1'b0;
            st_d.fa    = st_q.fa + ADDR_W'(WORD_BYTES);
        end else if (resp_live) begin
            st_d.pend  = 1'b0;
            st_d.stale = 1'b0;
        end
        if (redir_valid) begin
            st_d.fa    = {redir_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            st_d.stale = st_d.pend;
        end
    end

    assign mem_addr = st_q.fa;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fa    <= {RESET_ADDR[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            st_q.pend  <= 1'b0;
            st_q.stale <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wfp_word_buf.sv
module wfp_word_buf
    import wfp_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int BUF_WORDS  = 2,
    parameter int CNT_W      = 2,
    parameter int OFF_W      = 2,
    parameter logic [OFF_W-1:0] RESET_OFF = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              flush,
    input  logic [OFF_W-1:0]  flush_off,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_val,
    output logic [CNT_W-1:0]  cnt
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORD_BYTES - 1);

    typedef struct packed {
        logic [BUF_WORDS-1:0][WORD_W-1:0] slot;
        logic [CNT_W-1:0]                 cnt;
        logic [OFF_W-1:0]                 bptr;
    } bst_t;

    bst_t st_d, st_q;
    logic take, pop;

    always_comb begin
        st_d     = st_q;
        byte_vld = (st_q.cnt != '0);
        byte_val = st_q.slot[0][st_q.bptr*BYTE_W +: BYTE_W];
        take     = byte_vld && !flush;
        pop      = take && (st_q.bptr == LAST_OFF);
        if (take) begin
            st_d.bptr = st_q.bptr + 1'b1;
        end
        if (pop) begin
            for (int i = 0; i < BUF_WORDS - 1; i++) begin
                st_d.slot[i] = st_q.slot[i+1];
            end
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (push) begin
            for (int i = 0; i < BUF_WORDS; i++) begin
                if (CNT_W'(i) == st_d.cnt) begin
                    st_d.slot[i] = push_word;
                end
            end
            st_d.cnt = st_d.cnt + 1'b1;
        end
        if (flush) begin
            st_d.cnt  = '0;
            st_d.bptr = flush_off;
        end
    end

    assign cnt = st_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.slot <= '0;
            st_q.cnt  <= '0;
            st_q.bptr <= RESET_OFF;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wfp_opnd_acc.sv
module wfp_opnd_acc
    import wfp_pkg::*;
#(
    parameter int OPND_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              flush,
    output logic              iss_valid,
    output fn_t               iss_fn,
    output logic [OPND_W-1:0] iss_opnd
);
    typedef struct packed {
        logic [OPND_W-1:0] oreg;
        logic              vld;
        fn_t               fn;
        logic [OPND_W-1:0] opnd;
    } ost_t;

    ost_t st_d, st_q;
    fn_t  fn_w;
    logic [OPND_W-1:0] merged;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        fn_w     = byte_val[BYTE_W-1:NIB_W];
        merged   = st_q.oreg | OPND_W'(byte_val[NIB_W-1:0]);
        if (byte_vld && !flush) begin
            unique case (fn_w)
                FN_PFIX: st_d.oreg = merged << NIB_W;
                FN_NFIX: st_d.oreg = (~merged) << NIB_W;
                default: begin
                    st_d.vld  = 1'b1;
                    st_d.fn   = fn_w;
                    st_d.opnd = merged;
                    st_d.oreg = '0;
                end
            endcase
        end
        if (flush) begin
            st_d.oreg = '0;
            st_d.vld  = 1'b0;
        end
    end

    assign iss_valid = st_q.vld;
    assign iss_fn    = st_q.fn;
    assign iss_opnd  = st_q.opnd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bytecode_fetch_top.sv
module bytecode_fetch_top
    import wfp_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 32,
    parameter int OPND_W    = 32,
    parameter int BUF_WORDS = 2,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    input  logic              redir_valid,
    input  logic [ADDR_W-1:0] redir_addr,
    output logic              iss_valid,
    output logic [NIB_W-1:0]  iss_fn,
    output logic [OPND_W-1:0] iss_opnd
);
    localparam int WORD_BYTES = WORD_W / BYTE_W;
    localparam int OFF_W      = $clog2(WORD_BYTES);
    localparam int CNT_W      = $clog2(BUF_WORDS + 1);

    logic              push;
    logic [CNT_W-1:0]  buf_cnt;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_val;

    wfp_fetch_ctl #(
        .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .BUF_WORDS(BUF_WORDS),
        .CNT_W(CNT_W), .RESET_ADDR(RESET_ADDR)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .buf_cnt(buf_cnt), .mem_rvalid(mem_rvalid),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .push(push)
    );

    wfp_word_buf #(
        .WORD_W(WORD_W), .WORD_BYTES(WORD_BYTES), .BUF_WORDS(BUF_WORDS),
        .CNT_W(CNT_W), .OFF_W(OFF_W), .RESET_OFF(RESET_ADDR[OFF_W-1:0])
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .push(push), .push_word(mem_rdata),
        .flush(redir_valid), .flush_off(redir_addr[OFF_W-1:0]),
        .byte_vld(byte_vld), .byte_val(byte_val), .cnt(buf_cnt)
    );

    wfp_opnd_acc #(.OPND_W(OPND_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_val(byte_val),
        .flush(redir_valid), .iss_valid(iss_valid), .iss_fn(iss_fn),
        .iss_opnd(iss_opnd)
    );
endmodule

// File: rtl/bytecode_fetch_chk.sv
module bytecode_fetch_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              redir_valid,
    input logic [ADDR_W-1:0] redir_addr,
    input logic              iss_valid,
    input logic [3:0]        iss_fn
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r6_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    a_r7_quiet_after_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !iss_valid);

    a_r7_refetch_target: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(redir_valid) && mem_req)
            |-> (mem_addr[ADDR_W-1:OFF_W] == $past(redir_addr[ADDR_W-1:OFF_W])));

    a_r4_r5_prefix_not_issued: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_fn != 4'h2 && iss_fn != 4'h6));
endmodule

bind bytecode_fetch_top bytecode_fetch_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .redir_valid(redir_valid), .redir_addr(redir_addr),
    .iss_valid(iss_valid), .iss_fn(iss_fn)
);

// File: tb/sim_bytecode_fetch_top.sv
`timescale 1ns/1ps
module sim_bytecode_fetch_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        redir_valid = 1'b0;
    logic [31:0] redir_addr = '0;
    logic        iss_valid;
    logic [3:0]  iss_fn;
    logic [31:0] iss_opnd;

    int checks = 0;
    int errors = 0;
    int issues = 0;
    bit run = 1'b0;

    int p_redir = 60;
    int max_lat = 3;
    bit force_resp = 1'b0;
    bit plain_only = 1'b0;

    always #5 clk = ~clk;

    bytecode_fetch_top u0 (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .iss_valid(iss_valid), .iss_fn(iss_fn), .iss_opnd(iss_opnd)
    );

    // Program image: addresses with bit 20 set hold no prefix bytes.
    function automatic logic [7:0] prog_byte(input logic [31:0] a);
        logic [31:0] h;
        logic [3:0]  f;
        h = a * 32'h9E37_79B1;
        h = h ^ (h >> 15);
        h = h * 32'h85EB_CA6B;
        h = h ^ (h >> 13);
        f = h[7:4];
        if (a[20]) begin
            if (f == 4'h2 || f == 4'h6) f = f + 4'h1;
        end else if (h[9:8] == 2'd0) begin
            f = 4'h2;
        end else if (h[9:8] == 2'd1) begin
            f = 4'h6;
        end
        return {f, h[3:0]};
    endfunction

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return {prog_byte(a + 3), prog_byte(a + 2), prog_byte(a + 1), prog_byte(a)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model, redirect source and reference walk
    initial begin : drv
        bit out, out_stale, rv, rv_stale, quiet, first_req, stale_tag, in_plain;
        bit req_now, do_redir, sawp, sawn, found;
        int lat, acc_w, end_w;
        logic [31:0] out_addr, exp_fa, mpc, moreg, t, eop, tgt;
        logic [7:0]  b;
        logic [3:0]  efn;
        string tag;
        out = 0; out_stale = 0; rv = 0; rv_stale = 0; quiet = 0; first_req = 0;
        stale_tag = 0; in_plain = 0; lat = 0; acc_w = 0; end_w = 0;
        out_addr = '0; exp_fa = '0; mpc = '0; moreg = '0;
        forever begin
            @(negedge clk);
            if (run) begin
                // 1: issue port against the reference walk
                if (quiet) begin
                    check(!iss_valid, "R7 issue after redirect", {31'b0, iss_valid}, 32'd0);
                    quiet = 0;
                end
                if (iss_valid) begin
                    issues++;
                    sawp = 0; sawn = 0; found = 0; efn = '0; eop = '0;
                    for (int k = 0; k < 48; k++) begin
                        b = prog_byte(mpc);
                        if (mpc[1:0] == 2'd3) end_w++;
                        mpc = mpc + 1;
                        t = moreg | {28'b0, b[3:0]};
                        if (b[7:4] == 4'h2) begin
                            moreg = t << 4; sawp = 1;
                        end else if (b[7:4] == 4'h6) begin
                            moreg = (~t) << 4; sawn = 1;
                        end else begin
                            efn = b[7:4]; eop = t; moreg = '0; found = 1;
                            break;
                        end
                    end
                    tag = stale_tag ? "R8 stale data decoded" :
                          sawn ? "R5 negative prefix operand" :
                          sawp ? "R4 prefix operand" : "R3 plain operand";
                    check(found && iss_fn == efn, stale_tag ? "R8 stale fn" : "R2 fn/byte order",
                          {28'b0, iss_fn}, {28'b0, efn});
                    check(iss_opnd == eop, tag, iss_opnd, eop);
                    stale_tag = 0;
                end
                // 2: finish the response driven last cycle
                if (rv) begin
                    rv = 0; mem_rvalid = 1'b0; out = 0;
                    if (rv_stale) stale_tag = 1;
                    else if (in_plain) acc_w++;
                end
                // 3: new request
                req_now = mem_req;
                if (mem_req) begin
                    check(!out, "R6 second outstanding read", {31'b0, mem_req}, 32'd0);
                    check(mem_addr == exp_fa, first_req ? "R7 refetch address" : "R6 fetch address",
                          mem_addr, exp_fa);
                    if (in_plain)
                        check(acc_w - end_w <= 1, "R6 request with full buffer",
                              acc_w - end_w, 32'd1);
                    first_req = 0;
                    out = 1; out_stale = 0; out_addr = mem_addr;
                    lat = $urandom % max_lat;
                    exp_fa = exp_fa + 4;
                end
                // 4: drive a response for an older request
                if (out && !req_now && !rv) begin
                    if (lat == 0) begin
                        rv = 1; rv_stale = out_stale;
                        mem_rvalid = 1'b1; mem_rdata = word_at(out_addr);
                    end else begin
                        lat--;
                    end
                end
                // 5: redirect
                do_redir = ($urandom % p_redir == 0) || (force_resp && rv && $urandom % 2 == 0);
                if (do_redir) begin
                    if (plain_only || $urandom % 4 == 0) tgt = 32'h0010_0000 + ($urandom % 256);
                    else tgt = $urandom % 65536;
                    redir_valid = 1'b1; redir_addr = tgt;
                    if (out) out_stale = 1;
                    if (rv) rv_stale = 1;
                    mpc = tgt; moreg = '0; exp_fa = {tgt[31:2], 2'b00};
                    quiet = 1; first_req = 1; in_plain = tgt[20];
                    acc_w = 0; end_w = 0;
                end else begin
                    redir_valid = 1'b0; redir_addr = $urandom;
                end
            end
        end
    end

    initial begin : main
        process::self().srandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!iss_valid, "R1 iss_valid in reset", {31'b0, iss_valid}, 32'd0);
        check(mem_req, "R1 mem_req in reset", {31'b0, mem_req}, 32'd1);
        check(mem_addr == 32'd0, "R1 reset address", mem_addr, 32'd0);
        @(posedge clk);
        #1 rst_n = 1'b1; run = 1'b1;
        // random redirects, varying latency
        p_redir = 60; max_lat = 3;
        repeat (8000) @(posedge clk);
        // R8: redirect aimed at response cycles
        force_resp = 1'b1; p_redir = 1000;
        repeat (6000) @(posedge clk);
        // R6: prefix-free region with fast memory, buffer fills
        force_resp = 1'b0; plain_only = 1'b1; max_lat = 1; p_redir = 400;
        repeat (6000) @(posedge clk);
        // mixed, slow memory
        plain_only = 1'b0; max_lat = 5; p_redir = 90;
        repeat (6000) @(posedge clk);
        // back-to-back redirects
        p_redir = 2;
        repeat (500) @(posedge clk);
        p_redir = 1000000;
        repeat (200) @(posedge clk);
        @(negedge clk);
        check(issues > 1000, "R2 issue progress", issues, 32'd1000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule